// File: doc/BRIEF.md
# Time-Slot PCM Serial Port

This block is one side of a framed serial PCM link for a speech channel. A frame pulse, nominally repeating at 8 kHz, marks bit zero of each frame. A bit clock that is synchronous to that pulse divides the frame into 8-bit slots. In the one slot picked by a 5-bit slot number, the block does two things. It shifts a parallel byte out on the serial output, and it shifts a byte in from the serial input. The received byte is handed over with a one-clock strobe.

The two directions use opposite clock edges. Outgoing bits change on the rising edge of the bit clock. Incoming bits are taken on the falling edge, half a bit period later, so the far end has the full first half of the bit period to settle. Outside the chosen slot, and whenever the power-down input is high, the output driver is released to high impedance. Several such ports can therefore share one wire.

The whole block runs on the bit clock. Rising-edge registers track the bit position and drive the line. Falling-edge registers assemble the received byte.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is asserted, sd_oe_o is 0, rx_valid_o is 0 and rx_byte_o is 0x00.
- R2: Before the first rising edge at which fsync_i is high, no slot is active: sd_oe_o stays 0 and rx_valid_o stays 0.
- R3: A rising edge that samples fsync_i high makes that bit period bit 0 of the frame. Each later rising edge advances the position by one, wrapping after 256 bits. Slot s occupies frame bits 8*s to 8*s+7, with s given by slot_sel_i (0 to 31).
- R4: At the rising edge that opens the selected slot, the block takes tx_byte_i. Over the slot's 8 bits it drives that byte on sd_o, most significant bit first, one bit per rising edge. Changes to tx_byte_i later in the slot do not alter the bits sent.
- R5: During an active slot, sd_i is sampled on each falling edge of bclk_i. The first sample taken is the most significant bit of the received byte.
- R6: On the falling edge that captures the eighth bit of an active slot, rx_byte_o takes the assembled byte and rx_valid_o goes high for exactly one bit-clock period. rx_byte_o then holds until the next completed slot.
- R7: Outside the selected slot, sd_oe_o is 0 and sd_o is high impedance.
- R8: When pdown_i is sampled high at a rising edge, the output is disabled from that edge, and no receive strobe comes from the rest of that slot. A slot only becomes active if pdown_i is low at its first bit. Clearing pdown_i in the middle of a slot does not revive that slot.
- R9: A frame pulse arriving mid-frame realigns the bit position to 0 at once. A slot cut short this way ends without a receive strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Bit clock, synchronous with the frame pulse |
| rst_ni | input | 1 | Asynchronous active-low reset, released on a rising edge |
| fsync_i | input | 1 | Frame pulse, sampled on the rising edge |
| slot_sel_i | input | 5 | Selected slot number |
| pdown_i | input | 1 | Power-down for this side; high releases the output |
| sd_i | input | 1 | Serial data in, taken on falling edges |
| tx_byte_i | input | 8 | Byte to send in the next selected slot |
| sd_o | output | 1 | Serial data out, high impedance when not driven |
| sd_oe_o | output | 1 | High while sd_o is driven |
| rx_byte_o | output | 8 | Last complete received byte |
| rx_valid_o | output | 1 | One-clock strobe marking a new rx_byte_o |

## Verification
The bench targets the corner cases below, each chosen because a specific design error would show up there:
- **Slot edges, including the last slot before the frame wraps.** A design off by one would drive a bit of the neighbouring slot, or miss the final bit before the frame pulse.
- **The opposite-edge split.** A design that captured on the rising edge would collect the bit from before the change, and every received byte would be shifted by one bit.
- **Power-down, raised and dropped inside the slot.** A wrong design would keep driving, strobe a half-filled byte, or restart a slot partway through with stale transmit data.
- **A frame pulse that lands mid-slot.** Without an immediate realign, the byte would be misplaced. Without ending the cut-short slot, a spurious strobe would follow.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  // Default geometry of the framed link
  localparam int unsigned PCM_SLOT_W   = 5;  // slot number width: 32 slots
  localparam int unsigned PCM_SAMPLE_W = 8;  // bits per slot, power of two
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int unsigned SLOT_W   = pcm_slot_pkg::PCM_SLOT_W,
  parameter int unsigned SAMPLE_W = pcm_slot_pkg::PCM_SAMPLE_W,
  localparam int unsigned BIT_W   = $clog2(SAMPLE_W),
  localparam int unsigned POS_W   = SLOT_W + BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic [SLOT_W-1:0] slot_sel_i,
  input  logic              pdown_i,
  output logic              live_o,      // registered: current bit belongs to an active slot
  output logic [BIT_W-1:0]  bit_idx_o,   // registered: bit index inside the slot
  output logic              load_nxt_o,  // this edge opens an active slot
  output logic              shift_nxt_o  // this edge continues an active slot
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             locked_q, locked_d;
  logic             live_q, live_d;
  logic             slot_hit;
  logic             first_bit;

  // next-state
  always_comb begin
    pos_d     = fsync_i ? '0 : pos_q + POS_W'(1);
    locked_d  = locked_q | fsync_i;
    slot_hit  = locked_d && (pos_d[POS_W-1:BIT_W] == slot_sel_i);
    first_bit = (pos_d[BIT_W-1:0] == '0);
    if (first_bit) live_d = slot_hit & ~pdown_i;
    else           live_d = live_q & slot_hit & ~pdown_i;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      pos_q    <= pos_d;
      locked_q <= locked_d;
      live_q   <= live_d;
    end
  end

  assign live_o      = live_q;
  assign bit_idx_o   = pos_q[BIT_W-1:0];
  assign load_nxt_o  = live_d & first_bit;
  assign shift_nxt_o = live_d & ~first_bit;

  assert_sync_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (pos_q == '0));
  assert_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_i |=> (pos_q == POS_W'($past(pos_q) + POS_W'(1))));
  assert_pdown_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_i |=> !live_q);
  assert_unlocked_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && !fsync_i) |=> !live_q);
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int unsigned SAMPLE_W = pcm_slot_pkg::PCM_SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic [SAMPLE_W-1:0] tx_byte_i,
  output logic                bit_o
);
  logic [SAMPLE_W-1:0] sh_q, sh_d;
  logic                sh_en;

  always_comb begin
    sh_en = load_i | shift_i;
    if (load_i) sh_d = tx_byte_i;
    else        sh_d = {sh_q[SAMPLE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign bit_o = sh_q[SAMPLE_W-1];

  assert_latch_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sh_q == $past(tx_byte_i)));
  assert_msb_next_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (bit_o == $past(sh_q[SAMPLE_W-2])));
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
  parameter int unsigned SAMPLE_W = pcm_slot_pkg::PCM_SAMPLE_W,
  localparam int unsigned BIT_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                live_i,
  input  logic [BIT_W-1:0]    bit_idx_i,
  input  logic                sd_i,
  output logic [SAMPLE_W-1:0] rx_byte_o,
  output logic                rx_valid_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] acc_q, acc_d;
  logic [SAMPLE_W-1:0] byte_q;
  logic                valid_q, valid_d;
  logic                acc_en, byte_en;

  always_comb begin
    acc_en  = live_i;
    acc_d   = {acc_q[SAMPLE_W-2:0], sd_i};
    byte_en = live_i && (bit_idx_i == LAST_BIT);
    valid_d = byte_en;
  end

  // capture half a bit period after launch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (acc_en)  acc_q  <= acc_d;
      if (byte_en) byte_q <= acc_d;
    end
  end

  assign rx_byte_o  = byte_q;
  assign rx_valid_o = valid_q;

  assert_strobe_single_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_strobe_after_last_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (live_i && bit_idx_i == LAST_BIT) |=> valid_q);
  assert_quiet_off_slot_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !live_i |=> !valid_q);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int unsigned SLOT_W   = pcm_slot_pkg::PCM_SLOT_W,
  parameter int unsigned SAMPLE_W = pcm_slot_pkg::PCM_SAMPLE_W,
  localparam int unsigned BIT_W   = $clog2(SAMPLE_W)
) (
  input  logic                bclk_i,
  input  logic                rst_ni,
  input  logic                fsync_i,
  input  logic [SLOT_W-1:0]   slot_sel_i,
  input  logic                pdown_i,
  input  logic                sd_i,
  input  logic [SAMPLE_W-1:0] tx_byte_i,
  output logic                sd_o,
  output logic                sd_oe_o,
  output logic [SAMPLE_W-1:0] rx_byte_o,
  output logic                rx_valid_o
);
  logic             rst_n;
  logic             live;
  logic [BIT_W-1:0] bit_idx;
  logic             load_nxt, shift_nxt;
  logic             tx_bit;

  pcm_rst_sync u_rst (
    .clk_i       (bclk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  pcm_frame_timer #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) u_timer (
    .clk_i       (bclk_i),
    .rst_ni      (rst_n),
    .fsync_i     (fsync_i),
    .slot_sel_i  (slot_sel_i),
    .pdown_i     (pdown_i),
    .live_o      (live),
    .bit_idx_o   (bit_idx),
    .load_nxt_o  (load_nxt),
    .shift_nxt_o (shift_nxt)
  );

  pcm_tx_shifter #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk_i     (bclk_i),
    .rst_ni    (rst_n),
    .load_i    (load_nxt),
    .shift_i   (shift_nxt),
    .tx_byte_i (tx_byte_i),
    .bit_o     (tx_bit)
  );

  pcm_rx_shifter #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk_i      (bclk_i),
    .rst_ni     (rst_n),
    .live_i     (live),
    .bit_idx_i  (bit_idx),
    .sd_i       (sd_i),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o)
  );

  assign sd_oe_o = live;
  assign sd_o    = live ? tx_bit : 1'bz;

  assert_enable_in_reset_R1: assert property (@(posedge bclk_i)
    !rst_n |-> !sd_oe_o);
  assert_strobe_from_slot_R6: assert property (@(negedge bclk_i) disable iff (!rst_n)
    rx_valid_o |-> $past(sd_oe_o));
endmodule

// File: tb/tb_pcm_slot_port.sv
`timescale 1ns/1ps
module tb_pcm_slot_port;
  localparam int PERIOD = 8;  // 125 MHz

  logic       bclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic [4:0] slot = '0;
  logic       pdown = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] txb = '0;
  logic       sdo, sdo_en, rx_valid;
  logic [7:0] rx_byte;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit run_chk = 1'b0;
  string phase = "R2";

  // reference model state
  int       m_pos = 0;
  bit       m_locked = 0, m_live = 0, m_valid = 0;
  bit [7:0] m_tx = 0, m_acc = 0, m_data = 0;

  always #(PERIOD/2) bclk = ~bclk;

  pcm_slot_port dut (
    .bclk_i(bclk), .rst_ni(rst_n), .fsync_i(fsync), .slot_sel_i(slot),
    .pdown_i(pdown), .sd_i(sdi), .tx_byte_i(txb), .sd_o(sdo),
    .sd_oe_o(sdo_en), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model: rising edge (frame position, slot state, byte latch)
  always @(posedge bclk) begin
    if (!rst_n) begin
      m_pos = 0; m_locked = 0; m_live = 0;
    end else begin
      bit hit;
      if (fsync) begin m_pos = 0; m_locked = 1; end
      else m_pos = (m_pos + 1) % 256;
      hit = m_locked && ((m_pos / 8) == int'(slot));
      if (m_pos % 8 == 0) m_live = hit && !pdown;
      else                m_live = m_live && hit && !pdown;
      if (m_live && (m_pos % 8 == 0)) m_tx = txb;
    end
  end

  // transmit compare, after the rising-edge update
  always @(posedge bclk) begin
    #2;
    if (run_chk) begin
      string r;
      r = pdown ? "R8" : (m_live ? "R4" : "R7");
      chk(sdo_en == m_live, {phase, "/", r}, "output enable", int'(sdo_en), int'(m_live));
      if (m_live) chk(sdo == m_tx[7 - (m_pos % 8)], {phase, "/R4"}, "serial bit",
                      int'(sdo), int'(m_tx[7 - (m_pos % 8)]));
    end
  end

  // model: falling edge (capture) and receive compare
  always @(negedge bclk) begin
    if (!rst_n) begin
      m_valid = 0; m_acc = 0; m_data = 0;
    end else begin
      m_valid = 0;
      if (m_live) begin
        m_acc = {m_acc[6:0], sdi};
        if (m_pos % 8 == 7) begin m_valid = 1; m_data = m_acc; end
      end
    end
    #2;
    if (run_chk) begin
      chk(rx_valid == m_valid, {phase, "/R6"}, "rx strobe", int'(rx_valid), int'(m_valid));
      chk(rx_byte == m_data, {phase, "/R5"}, "rx byte", int'(rx_byte), int'(m_data));
    end
  end

  // watchdog
  always @(posedge bclk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  // one bit period: inputs change just after the rising edge
  task automatic tick(input bit f, input bit p);
    fsync = f;
    pdown = p;
    txb   = 8'($urandom);
    sdi   = 1'($urandom);
    @(posedge bclk); #1;
  endtask

  initial begin
    repeat (3) @(posedge bclk);
    #1;
    // R1: reset state
    chk(sdo_en == 1'b0, "R1", "oe in reset", int'(sdo_en), 0);
    chk(rx_valid == 1'b0, "R1", "valid in reset", int'(rx_valid), 0);
    chk(rx_byte == 8'h00, "R1", "byte in reset", int'(rx_byte), 0);
    rst_n = 1'b1;
    run_chk = 1'b1;
    // R2: no frame pulse yet, nothing active
    phase = "R2";
    slot = 5'd0;
    for (int i = 0; i < 20; i++) tick(0, 0);
    // R3/R4/R5: slot 0 right after the pulse, twice
    phase = "R3";
    for (int i = 0; i < 300; i++) tick(i % 256 == 0, 0);
    // R3: a middle slot
    slot = 5'd6;
    for (int i = 0; i < 530; i++) tick(i % 256 == 0, 0);
    // R3: last slot, ends right before the next pulse
    slot = 5'd31;
    for (int i = 0; i < 530; i++) tick(i % 256 == 0, 0);
    // R8: power-down raised inside the slot, then lowered inside the slot
    phase = "R8";
    slot = 5'd2;
    for (int i = 0; i < 256; i++) tick(i == 0, (i >= 19 && i < 22));
    for (int i = 0; i < 256; i++) tick(i == 0, (i >= 15 && i < 18));
    // R8: power-down across a whole frame
    for (int i = 0; i < 256; i++) tick(i == 0, 1);
    // R9: pulse lands in the middle of slot 1, and mid-frame elsewhere
    phase = "R9";
    slot = 5'd1;
    for (int i = 0; i < 40; i++) tick(i == 0 || i == 12, 0);
    for (int i = 0; i < 300; i++) tick(i == 0 || i == 77, 0);
    // R7: slot change between frames, plus trailing idle
    phase = "R7";
    slot = 5'd17;
    for (int i = 0; i < 300; i++) tick(i % 256 == 0, 0);
    run_chk = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule